// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write port of a parallel NOR-style flash and turns the stream of bus writes into operations. Each write arrives as a one-clock strobe with its address and data. The decoder recognises the two-write unlock prefix, follows the multi-write sequences for program, erase, lock and configuration, and emits each finished command as a one-clock operation pulse. The pulse carries an operation code and the captured address and data fields.

The decoder also keeps the bank's mode: array read, autoselect, unlock bypass or erase-suspend read. In bypass mode a program needs only two writes. Suspend and resume are single writes that take effect only while a sector erase is running or while erase is suspended. An erase engine outside the block reports that a sector erase is running through `erase_busy`. A write that does not fit the sequence in progress discards that sequence and produces nothing. That write is not taken as the start of a new sequence.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `mode` is 0 (array read) and `op_valid` is low.
- R2: The unlock prefix is code AA at low address 555 followed by code 55 at low address 2AA. A third write of 90 at low address 555 emits op kind 8 (ID) and sets `mode` to 1 (autoselect). This is accepted in any mode except bypass.
- R3: After the unlock prefix, a write of A0 at 555 followed by any write emits op kind 1 (program). That op carries the full address and all 16 data bits of the last write.
- R4: Erase is accepted only from `mode` 0. It takes the unlock prefix, 80 at 555, and a second unlock prefix. A sixth write of 10 at 555 then emits kind 2 (chip erase), or a sixth write of 30 at any address emits kind 3 (sector erase) with that address.
- R5: After the unlock prefix, 20 at 555 in `mode` 0 enters bypass (`mode` 2) and emits nothing. In bypass, A0 followed by any write emits kind 1. A write of 90 followed by 00 emits kind 10 and returns `mode` to 0. In bypass, F0 has no effect.
- R6: A single write of B0 emits kind 4 (suspend), carrying the write address. It also sets `mode` to 3 (erase-suspend read). It is accepted only while `erase_busy` is high and `mode` is 0; otherwise it has no effect.
- R7: A single write of 30 in `mode` 3 emits kind 5 (resume) and sets `mode` to 0.
- R8: A single write of F0 emits kind 10 (reset) outside bypass. It sets `mode` to 3 if erase is suspended, including from an autoselect entered while suspended. Otherwise it sets `mode` to 0.
- R9: In `mode` 0, three writes of 60 emit kind 6 (lock) carrying the third write's address. `op_data[0]` is that address's bit 6 (1 unlocks, 0 locks) and the other data bits are 0.
- R10: After the unlock prefix in `mode` 0, C0 at 555 emits kind 7 (configuration). `op_data` is address bits 17..12 of that write, zero-extended.
- R11: A single write of 98 at low address 055 emits kind 9 (query) in `mode` 0 or 1. In other modes it has no effect.
- R12: Matching of sequence codes uses only data bits 7..0 and address bits 11..0.
- R13: A write that does not fit the sequence in progress discards that sequence. It emits nothing, leaves `mode` unchanged, and is not taken as the start of a new sequence.
- R14: `op_valid` is high for exactly the one clock after the edge that samples the completing write. Ops other than program, lock and configuration carry the low data byte zero-extended. Without a write, neither `op_valid` nor `mode` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One-clock bus write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| erase_busy | input | 1 | High while a sector erase is running |
| op_valid | output | 1 | Operation pulse |
| op_kind | output | 4 | Operation code (see requirements) |
| op_addr | output | ADDR_W | Address of the completing write |
| op_data | output | DATA_W | Operation data field |
| mode | output | 2 | 0 read, 1 autoselect, 2 bypass, 3 erase-suspend read |

## Verification
Every result is due exactly one clock after the edge that samples the completing write. The operation pulse, its fields and the new mode all appear on the registered outputs together. The bench reference model updates its expectations at that same sampling edge and compares all outputs at the following falling edge, every clock. This catches a pulse that is late, stretched or missing, and a mode that changes one cycle off. Directed sequences cover each mode transition, rejected commands and aborts. A randomised burst of writes drawn from the command codes then exercises the interleavings.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              erase_busy,
  output logic              op_valid,
  output logic [3:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic [1:0]        mode
);
  localparam int CFG_LO   = 12;
  localparam int CFG_W    = 6;
  localparam int LOCK_BIT = 6;

  localparam logic [1:0] M_READ = 2'd0, M_AUTO = 2'd1, M_BYP = 2'd2, M_SUSP = 2'd3;
  localparam logic [3:0] K_NONE = 4'd0, K_PROG = 4'd1, K_CHIP = 4'd2, K_SECT = 4'd3,
                         K_SUSP = 4'd4, K_RES = 4'd5, K_LOCK = 4'd6, K_CFG = 4'd7,
                         K_ID = 4'd8, K_QRY = 4'd9, K_RST = 4'd10;

  typedef enum logic [3:0] {
    S_IDLE, S_U1, S_U2, S_E3, S_E4, S_E5, S_L1, S_L2, S_PGM, S_BX
  } seq_t;

  seq_t seq, seq_n;
  logic [1:0] mode_n;
  logic susp, susp_n;
  logic [3:0] kind;
  logic [DATA_W-1:0] dsel;
  logic [7:0] cd;
  logic at555, at2aa, at055, rd;

  assign cd    = wr_data[7:0];
  assign at555 = wr_addr[11:0] == 12'h555;
  assign at2aa = wr_addr[11:0] == 12'h2AA;
  assign at055 = wr_addr[11:0] == 12'h055;
  assign rd    = mode == M_READ;

  always_comb begin
    seq_n  = wr_valid ? S_IDLE : seq;
    mode_n = mode;
    susp_n = susp;
    kind   = K_NONE;
    dsel   = {{(DATA_W-8){1'b0}}, cd};
    if (wr_valid) begin
      case (seq)
        S_IDLE: begin
          if (mode == M_BYP) begin
            if (cd == 8'hA0) seq_n = S_PGM;
            else if (cd == 8'h90) seq_n = S_BX;
          end else if (cd == 8'hAA && at555) begin
            seq_n = S_U1;
          end else if (cd == 8'hF0) begin
            kind   = K_RST;
            mode_n = susp ? M_SUSP : M_READ;
          end else if (cd == 8'hB0 && rd && erase_busy) begin
            kind   = K_SUSP;
            mode_n = M_SUSP;
            susp_n = 1'b1;
          end else if (cd == 8'h30 && mode == M_SUSP) begin
            kind   = K_RES;
            mode_n = M_READ;
            susp_n = 1'b0;
          end else if (cd == 8'h98 && at055 && (rd || mode == M_AUTO)) begin
            kind = K_QRY;
          end else if (cd == 8'h60 && rd) begin
            seq_n = S_L1;
          end
        end
        S_U1: if (cd == 8'h55 && at2aa) seq_n = S_U2;
        S_U2: if (at555) begin
          case (cd)
            8'h90: begin kind = K_ID; mode_n = M_AUTO; end
            8'hA0: seq_n = S_PGM;
            8'h80: if (rd) seq_n = S_E3;
            8'h20: if (rd) mode_n = M_BYP;
            8'hC0: if (rd) begin
              kind = K_CFG;
              dsel = {{(DATA_W-CFG_W){1'b0}}, wr_addr[CFG_LO+CFG_W-1:CFG_LO]};
            end
            default: ;
          endcase
        end
        S_E3: if (cd == 8'hAA && at555) seq_n = S_E4;
        S_E4: if (cd == 8'h55 && at2aa) seq_n = S_E5;
        S_E5: begin
          if (cd == 8'h10 && at555) kind = K_CHIP;
          else if (cd == 8'h30) kind = K_SECT;
        end
        S_L1: if (cd == 8'h60) seq_n = S_L2;
        S_L2: if (cd == 8'h60) begin
          kind = K_LOCK;
          dsel = {{(DATA_W-1){1'b0}}, wr_addr[LOCK_BIT]};
        end
        S_PGM: begin
          kind = K_PROG;
          dsel = wr_data;
        end
        S_BX: if (cd == 8'h00) begin
          kind   = K_RST;
          mode_n = M_READ;
        end
        default: seq_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq      <= S_IDLE;
      mode     <= M_READ;
      susp     <= 1'b0;
      op_valid <= 1'b0;
      op_kind  <= K_NONE;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      seq      <= seq_n;
      mode     <= mode_n;
      susp     <= susp_n;
      op_valid <= kind != K_NONE;
      if (kind != K_NONE) begin
        op_kind <= kind;
        op_addr <= wr_addr;
        op_data <= dsel;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              erase_busy,
  input logic              op_valid,
  input logic [3:0]        op_kind,
  input logic [DATA_W-1:0] op_data,
  input logic [1:0]        mode
);
  a_r14_op_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> $past(wr_valid));
  a_r14_mode_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable(mode));
  a_r14_no_op_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> !op_valid);
  a_r6_suspend_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 4'd4) |-> ($past(erase_busy) && mode == 2'd3));
  a_r7_resume_to_read: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 4'd5) |-> (mode == 2'd0 && $past(mode) == 2'd3));
  a_r11_query_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 4'd9) |-> ($past(wr_addr[11:0]) == 12'h055));
  a_r10_cfg_field: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 4'd7) |-> (op_data[DATA_W-1:6] == '0));
  a_r2_id_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 4'd8) |-> mode == 2'd1);
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .erase_busy(erase_busy), .op_valid(op_valid), .op_kind(op_kind),
  .op_data(op_data), .mode(mode)
);

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
  localparam int AW = 23;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic erase_busy = 1'b0;
  logic op_valid;
  logic [3:0] op_kind;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  logic [1:0] mode;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW)) i_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .erase_busy(erase_busy), .op_valid(op_valid),
    .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data), .mode(mode)
  );

  // Reference model: keeps the raw writes of the pending sequence and
  // classifies the whole history on each new write.
  logic [11:0] ha[$];
  logic [7:0]  hd[$];
  int m = 0;
  bit s = 0;
  bit e_valid = 0;
  int e_kind = 0;
  logic [AW-1:0] e_addr = '0;
  logic [DW-1:0] e_data = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ha.delete(); hd.delete();
      m = 0; s = 0; e_valid = 0;
    end else begin
      e_valid = 0;
      if (wr_valid) begin
        int n, verdict, k;
        logic [DW-1:0] dv;
        ha.push_back(wr_addr[11:0]);
        hd.push_back(wr_data[7:0]);
        n = ha.size();
        verdict = 0; k = 0;
        dv = {8'h00, wr_data[7:0]};
        if (m == 2) begin
          if (n == 1) verdict = (hd[0] == 8'hA0 || hd[0] == 8'h90) ? 1 : 0;
          else if (hd[0] == 8'hA0) begin verdict = 2; k = 1; dv = wr_data; end
          else if (hd[1] == 8'h00) begin verdict = 2; k = 10; m = 0; end
        end else if (hd[0] == 8'h60 && m == 0) begin
          if (hd[n-1] != 8'h60) verdict = 0;
          else if (n < 3) verdict = 1;
          else begin verdict = 2; k = 6; dv = {15'b0, wr_addr[6]}; end
        end else if (hd[0] == 8'hAA && ha[0] == 12'h555) begin
          case (n)
            1: verdict = 1;
            2: verdict = (hd[1] == 8'h55 && ha[1] == 12'h2AA) ? 1 : 0;
            3: if (ha[2] == 12'h555) begin
              if (hd[2] == 8'h90) begin verdict = 2; k = 8; m = 1; end
              else if (hd[2] == 8'hA0) verdict = 1;
              else if (hd[2] == 8'h80 && m == 0) verdict = 1;
              else if (hd[2] == 8'h20 && m == 0) begin verdict = 2; m = 2; end
              else if (hd[2] == 8'hC0 && m == 0) begin
                verdict = 2; k = 7; dv = {10'b0, wr_addr[17:12]};
              end
            end
            4: if (hd[2] == 8'hA0) begin verdict = 2; k = 1; dv = wr_data; end
               else verdict = (hd[3] == 8'hAA && ha[3] == 12'h555) ? 1 : 0;
            5: verdict = (hd[4] == 8'h55 && ha[4] == 12'h2AA) ? 1 : 0;
            6: if (hd[5] == 8'h10 && ha[5] == 12'h555) begin verdict = 2; k = 2; end
               else if (hd[5] == 8'h30) begin verdict = 2; k = 3; end
            default: verdict = 0;
          endcase
        end else if (n == 1) begin
          if (hd[0] == 8'hF0) begin k = 10; m = s ? 3 : 0; end
          else if (hd[0] == 8'hB0 && m == 0 && erase_busy) begin k = 4; m = 3; s = 1; end
          else if (hd[0] == 8'h30 && m == 3) begin k = 5; m = 0; s = 0; end
          else if (hd[0] == 8'h98 && ha[0] == 12'h055 && m <= 1) k = 9;
        end
        if (k != 0) begin
          e_valid = 1; e_kind = k; e_addr = wr_addr; e_data = dv;
        end
        if (verdict != 1) begin ha.delete(); hd.delete(); end
      end
    end
  end

  function automatic string req_of(int k);
    case (k)
      1: return "R3"; 2, 3: return "R4"; 4: return "R6"; 5: return "R7";
      6: return "R9"; 7: return "R10"; 8: return "R2"; 9: return "R11";
      default: return "R8";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (op_valid !== e_valid) begin
        errors++;
        $display("FAIL R14 op_valid actual %0b expected %0b", op_valid, e_valid);
      end
      checks++;
      if (mode !== 2'(m)) begin
        errors++;
        $display("FAIL R13 mode actual %0d expected %0d", mode, m);
      end
      if (e_valid && op_valid) begin
        checks++;
        if (op_kind !== 4'(e_kind) || op_addr !== e_addr || op_data !== e_data) begin
          errors++;
          $display("FAIL %s op actual %0d/%h/%h expected %0d/%h/%h", req_of(e_kind),
                   op_kind, op_addr, op_data, e_kind, e_addr, e_data);
        end
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock();
    wr(23'h000555, 16'h00AA);
    wr(23'h0002AA, 16'h0055);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    gap(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (mode !== 2'd0 || op_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 mode/op_valid actual %0d/%0b expected 0/0", mode, op_valid);
    end
    // R2 and R12: ID entry with junk upper data and high address bits
    wr(23'h7F1555, 16'hC3AA);
    wr(23'h4002AA, 16'hFF55);
    wr(23'h200555, 16'h1290);
    gap(1);
    // R11: query in autoselect, then ignored in bypass later
    wr(23'h000055, 16'h0098);
    // R8: reset back to read
    wr(23'h012345, 16'h00F0);
    gap(2);
    // R3: normal program
    unlock(); wr(23'h000555, 16'h00A0); wr(23'h3ABCDE, 16'hBEEF);
    gap(1);
    // R4: chip erase and sector erase
    unlock(); wr(23'h000555, 16'h0080); unlock(); wr(23'h000555, 16'h0010);
    unlock(); wr(23'h000555, 16'h0080); unlock(); wr(23'h56A000, 16'h0030);
    gap(1);
    // R4: erase prefix refused from autoselect
    unlock(); wr(23'h000555, 16'h0090);
    unlock(); wr(23'h000555, 16'h0080); unlock(); wr(23'h000555, 16'h0010);
    // R13: abort in autoselect, F0 not reinterpreted
    wr(23'h000555, 16'h00AA); wr(23'h000000, 16'h00F0);
    wr(23'h000000, 16'h00F0);
    gap(1);
    // R6: suspend ignored without busy, then accepted
    wr(23'h600000, 16'h00B0);
    erase_busy = 1'b1;
    wr(23'h600000, 16'h00B0);
    erase_busy = 1'b0;
    // R11: query ignored in suspend; R8: autoselect in suspend, reset to suspend
    wr(23'h000055, 16'h0098);
    unlock(); wr(23'h000555, 16'h0090);
    wr(23'h000000, 16'h00F0);
    // R7: resume
    wr(23'h600000, 16'h0030);
    // R7: resume ignored in read
    wr(23'h600000, 16'h0030);
    gap(1);
    // R9: lock and unlock
    wr(23'h000000, 16'h0060); wr(23'h000000, 16'h0060); wr(23'h12A000, 16'h0060);
    wr(23'h000000, 16'h0060); wr(23'h000000, 16'h0060); wr(23'h12A040, 16'h0060);
    // R10: configuration from address bits 17..12
    unlock(); wr(23'h02D555, 16'h00C0);
    gap(1);
    // R5: bypass entry, fast program, F0 ignored, query ignored, exit
    unlock(); wr(23'h000555, 16'h0020);
    wr(23'h000000, 16'h00A0); wr(23'h111111, 16'h1234);
    wr(23'h000000, 16'h00F0);
    wr(23'h000055, 16'h0098);
    wr(23'h200000, 16'h0090); wr(23'h000000, 16'h0000);
    gap(2);
    // R13: broken unlock mid-erase emits nothing
    unlock(); wr(23'h000555, 16'h0080); wr(23'h000555, 16'h0055);
    // Random burst over the command codes (R12, R13, R14)
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] pool [12];
      logic [11:0] apool [4];
      pool = '{8'hAA, 8'h55, 8'h90, 8'hA0, 8'h80, 8'h20, 8'hC0,
               8'h10, 8'h30, 8'h60, 8'hB0, 8'hF0};
      apool = '{12'h555, 12'h2AA, 12'h055, 12'h123};
      erase_busy = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 3) == 0) gap(1);
      else if ($urandom_range(0, 15) == 0)
        wr({11'($urandom), apool[$urandom_range(0, 3)]}, {8'($urandom), 8'h98});
      else
        wr({11'($urandom), apool[$urandom_range(0, 3)]},
           {8'($urandom), pool[$urandom_range(0, 11)]});
    end
    gap(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule